// File: doc/BRIEF.md
# Row-Programmed Nonvolatile Data Store Controller

This block fronts a small nonvolatile data memory of 128 rows with 16 bytes each, 2 KB in total. Reads go straight to the storage and may address any byte. Each read is a single request that returns its byte one cycle later. Writes cannot address single bytes. Software first fills a 16-byte row buffer one byte at a time. It then issues a command that erases a target row, programs the buffered bytes into that row, or does both in sequence. The storage cells are modelled as a register array, and the memory has no error correction.

A row operation runs in the background. While it runs, `busy` is high for a fixed number of cycles per phase, and a one-cycle `done` pulse marks the end. Reads of every other row keep being served at full rate during that time. Any byte of the row under operation reads as 8'hFF until the operation finishes. A command that arrives while the controller is busy is rejected with a one-cycle `err` pulse, and so is a command with an undefined code. Neither port applies back-pressure: every command and every read request is consumed in the cycle it is presented, and a read response is never held off.

Top module: `eeprom_row_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `rd_data_valid` are low, the row buffer holds 8'hFF in every slot, and every stored byte reads as 8'hFF.
- R2: A read request sampled with `rd_valid` high at a clock edge makes `rd_data_valid` high for exactly the next cycle. In that cycle `rd_data` holds the byte at `rd_addr`, where `rd_addr[10:4]` selects the row and `rd_addr[3:0]` selects the byte within it. Without a request, `rd_data_valid` stays low.
- R3: Opcode 3'b001 (load) writes `cmd_data` into buffer slot `cmd_offset`. It completes in one cycle, leaves `busy` and `err` low, and changes no stored byte.
- R4: Opcode 3'b010 (erase) holds `busy` high for ERASE_CYCLES cycles and then leaves all 16 bytes of `cmd_row` at 8'hFF.
- R5: Opcode 3'b011 (program) holds `busy` high for PROG_CYCLES cycles and then leaves the 16 buffered bytes in `cmd_row`, with buffer slot k going to byte k.
- R6: Opcode 3'b100 (erase then program) holds `busy` high for ERASE_CYCLES+PROG_CYCLES cycles and then leaves the buffered bytes in `cmd_row`.
- R7: `done` is high for exactly one cycle, the first cycle after `busy` falls, and at no other time.
- R8: A command presented while `busy` is high is rejected. `err` is high in the next cycle, and neither the row buffer nor any stored byte is changed by it.
- R9: Opcodes 3'b000, 3'b101, 3'b110 and 3'b111 produce an `err` pulse in the next cycle, do not raise `busy`, and change no stored byte.
- R10: While `busy` is high, a read of any byte in the row under operation returns 8'hFF, and a read of any other row returns that row's stored data with the normal one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command presented this cycle |
| cmd_op | input | 3 | Command code |
| cmd_row | input | 7 | Target row for erase/program |
| cmd_offset | input | 4 | Buffer slot for load |
| cmd_data | input | 8 | Byte for load |
| busy | output | 1 | Row operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 11 | Byte address of the read |
| rd_data_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |

## Verification
The checker assumes that `cmd_op` is defined whenever `cmd_valid` is high and that `rd_addr` is defined whenever `rd_valid` is high. It also tracks the target row from accepted erase and program commands only, so it relies on the bench never expecting a rejected command to change that row. The bench drives every input on the falling edge and lowers `cmd_valid` and `rd_valid` between requests. It sends commands during `busy` only in the dedicated rejection phase, and it waits for `busy` to fall before starting the next row operation, so every observed busy window belongs to one accepted command.

// File: rtl/eerow_pkg.sv
package eerow_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_PROG   = 3'd3,
    OP_ERPROG = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2
  } phase_e;

  localparam logic [7:0] BLANK = 8'hFF;
endpackage

// File: rtl/eerow_latch.sv
module eerow_latch
  import eerow_pkg::*;
#(
  parameter int ROW_BYTES = 16,
  parameter int OFS_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic [OFS_W-1:0]       load_ofs,
  input  logic [7:0]             load_data,
  output logic [ROW_BYTES*8-1:0] row_bits
);
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
    logic [7:0] slot;
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot <= BLANK;
      else if (load_en && load_ofs == OFS_W'(g))
        slot <= load_data;
    end
    assign row_bits[g*8 +: 8] = slot;
  end
endmodule

// File: rtl/eerow_seq.sv
module eerow_seq
  import eerow_pkg::*;
#(
  parameter int ROW_W        = 7,
  parameter int ERASE_CYCLES = 6,
  parameter int PROG_CYCLES  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             load_en,
  output logic             commit_en,
  output logic             commit_fill,
  output logic [ROW_W-1:0] tgt_row
);
  localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PROG_CYCLES - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             chain;
  logic             take;
  logic             last;

  assign busy        = (phase != PH_IDLE);
  assign take        = cmd_valid && !busy;
  assign load_en     = take && (cmd_op == OP_LOAD);
  assign last        = busy && (cnt == '0);
  assign commit_en   = last;
  assign commit_fill = (phase == PH_ERASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      chain   <= 1'b0;
      tgt_row <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (cmd_valid && busy) begin
        err <= 1'b1;
      end else if (take) begin
        case (op_e'(cmd_op))
          OP_LOAD: ;
          OP_ERASE: begin
            phase   <= PH_ERASE;
            cnt     <= E_LAST;
            chain   <= 1'b0;
            tgt_row <= cmd_row;
          end
          OP_PROG: begin
            phase   <= PH_PROG;
            cnt     <= P_LAST;
            chain   <= 1'b0;
            tgt_row <= cmd_row;
          end
          OP_ERPROG: begin
            phase   <= PH_ERASE;
            cnt     <= E_LAST;
            chain   <= 1'b1;
            tgt_row <= cmd_row;
          end
          default: err <= 1'b1;
        endcase
      end
      if (last) begin
        if (phase == PH_ERASE && chain) begin
          phase <= PH_PROG;
          cnt   <= P_LAST;
          chain <= 1'b0;
        end else begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/eerow_array.sv
module eerow_array
  import eerow_pkg::*;
#(
  parameter int ROWS      = 128,
  parameter int ROW_BYTES = 16,
  parameter int ROW_W     = 7,
  parameter int OFS_W     = 4,
  parameter int ADDR_W    = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_en,
  input  logic                   commit_fill,
  input  logic [ROW_W-1:0]       commit_row,
  input  logic [ROW_BYTES*8-1:0] row_bits,
  input  logic                   busy,
  input  logic                   rd_valid,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic                   rd_data_valid,
  output logic [7:0]             rd_data
);
  localparam int DEPTH = ROWS * ROW_BYTES;

  logic [7:0]       cells [DEPTH];
  logic [ROW_W-1:0] rd_row;

  assign rd_row = rd_addr[ADDR_W-1:OFS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= BLANK;
    end else if (commit_en) begin
      for (int j = 0; j < ROW_BYTES; j++)
        cells[{commit_row, OFS_W'(j)}] <= commit_fill ? BLANK : row_bits[j*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_valid <= 1'b0;
      rd_data       <= '0;
    end else begin
      rd_data_valid <= rd_valid;
      if (rd_valid)
        rd_data <= (busy && rd_row == commit_row) ? BLANK : cells[rd_addr];
    end
  end
endmodule

// File: rtl/eeprom_row_ctrl.sv
module eeprom_row_ctrl #(
  parameter int ROWS         = 128,
  parameter int ROW_BYTES    = 16,
  parameter int ERASE_CYCLES = 6,
  parameter int PROG_CYCLES  = 10,
  localparam int ROW_W       = $clog2(ROWS),
  localparam int OFS_W       = $clog2(ROW_BYTES),
  localparam int ADDR_W      = ROW_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [OFS_W-1:0]  cmd_offset,
  input  logic [7:0]        cmd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data_valid,
  output logic [7:0]        rd_data
);
  logic                   load_en;
  logic                   commit_en;
  logic                   commit_fill;
  logic [ROW_W-1:0]       tgt_row;
  logic [ROW_BYTES*8-1:0] row_bits;

  eerow_seq #(
    .ROW_W(ROW_W), .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .busy(busy), .done(done), .err(err),
    .load_en(load_en), .commit_en(commit_en), .commit_fill(commit_fill),
    .tgt_row(tgt_row)
  );

  eerow_latch #(.ROW_BYTES(ROW_BYTES), .OFS_W(OFS_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_ofs(cmd_offset),
    .load_data(cmd_data), .row_bits(row_bits)
  );

  eerow_array #(
    .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .ROW_W(ROW_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .commit_en(commit_en), .commit_fill(commit_fill),
    .commit_row(tgt_row), .row_bits(row_bits), .busy(busy),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/eeprom_row_ctrl_chk.sv
module eeprom_row_ctrl_chk #(
  parameter int ROW_W        = 7,
  parameter int ERASE_CYCLES = 6,
  parameter int PROG_CYCLES  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [ROW_W-1:0] cmd_row,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             rd_valid,
  input logic [ROW_W-1:0] rd_row,
  input logic             rd_data_valid,
  input logic [7:0]       rd_data
);
  localparam int BC_W = $clog2(ERASE_CYCLES + PROG_CYCLES + 2);

  logic [ROW_W-1:0] trk_row;
  logic [BC_W-1:0]  bcnt;
  logic             row_cmd;
  logic             bad_cmd;

  assign row_cmd = cmd_valid && !busy && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4);
  assign bad_cmd = cmd_valid && !busy && (cmd_op == 3'd0 || cmd_op > 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_row <= '0;
      bcnt    <= '0;
    end else begin
      if (row_cmd) trk_row <= cmd_row;
      bcnt <= busy ? bcnt + 1'b1 : '0;
    end
  end

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> err);

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> (err && !busy));

  // R3
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd1) |=> (!busy && !err));

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_data_valid);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_data_valid);

  // R10
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && busy && rd_row == trk_row) |=> (rd_data == 8'hFF));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(bcnt) == ERASE_CYCLES || int'(bcnt) == PROG_CYCLES ||
                     int'(bcnt) == ERASE_CYCLES + PROG_CYCLES));
endmodule

bind eeprom_row_ctrl eeprom_row_ctrl_chk #(
  .ROW_W(ROW_W), .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
  .busy(busy), .done(done), .err(err), .rd_valid(rd_valid),
  .rd_row(rd_addr[ADDR_W-1:OFS_W]), .rd_data_valid(rd_data_valid), .rd_data(rd_data)
);

// File: tb/eeprom_row_ctrl_test.sv
module eeprom_row_ctrl_test;
  localparam int ROWS = 128;
  localparam int RB   = 16;
  localparam int E    = 6;
  localparam int P    = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [6:0]  cmd_row;
  logic [3:0]  cmd_offset;
  logic [7:0]  cmd_data;
  logic        busy, done, err;
  logic        rd_valid;
  logic [10:0] rd_addr;
  logic        rd_data_valid;
  logic [7:0]  rd_data;

  always #10 clk = ~clk;

  eeprom_row_ctrl #(.ROWS(ROWS), .ROW_BYTES(RB), .ERASE_CYCLES(E), .PROG_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row),
    .cmd_offset(cmd_offset), .cmd_data(cmd_data), .busy(busy), .done(done), .err(err),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data_valid(rd_data_valid), .rd_data(rd_data)
  );

  int vecs = 0;
  int errs = 0;
  logic [7:0] mdl  [ROWS*RB];
  logic [7:0] mbuf [RB];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int r, int o, logic [7:0] salt);
    return 8'((r * 7 + o * 13 + 5)) ^ salt;
  endfunction

  task automatic read_chk(string req, int addr, logic [7:0] exp);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = 11'(addr);
    @(negedge clk);
    rd_valid = 1'b0;
    chk(req, {rd_data_valid, rd_data}, {1'b1, exp});
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < ROWS * RB; a++) read_chk(req, a, mdl[a]);
  endtask

  task automatic load(int ofs, logic [7:0] d);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = 3'd1;
    cmd_offset = 4'(ofs);
    cmd_data   = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3 load keeps busy/err low", {busy, err}, 2'b00);
    mbuf[ofs] = d;
  endtask

  task automatic run_op(logic [2:0] op, int row, string req);
    int exp_len;
    int n;
    int other;
    logic [7:0] exp;
    exp_len = (op == 3'd2) ? E : (op == 3'd3) ? P : E + P;
    n = 0;
    other = (row + 1) % ROWS;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_row   = 7'(row);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy && n < 1000) begin
      n++;
      rd_valid = 1'b1;
      if (n % 2 == 1) begin
        rd_addr = 11'(row * RB + n % RB);
        exp = 8'hFF;
      end else begin
        rd_addr = 11'(other * RB + n % RB);
        exp = mdl[other * RB + n % RB];
      end
      @(negedge clk);
      rd_valid = 1'b0;
      chk("R10 read during busy", {rd_data_valid, rd_data}, {1'b1, exp});
    end
    chk({req, " busy length"}, 32'(n), 32'(exp_len));
    chk("R7 done after busy", {done, busy}, 2'b10);
    for (int k = 0; k < RB; k++) mdl[row * RB + k] = (op == 3'd2) ? 8'hFF : mbuf[k];
    @(negedge clk);
    chk("R7 done single pulse", done, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vecs++;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = '0;
    cmd_row = '0;
    cmd_offset = '0;
    cmd_data = '0;
    rd_valid = 1'b0;
    rd_addr = '0;
    for (int a = 0; a < ROWS * RB; a++) mdl[a] = 8'hFF;
    for (int k = 0; k < RB; k++) mbuf[k] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {busy, done, err, rd_data_valid}, 4'b0000);
    @(negedge clk);
    chk("R2 no request no valid", rd_data_valid, 1'b0);
    sweep("R1 reset contents");

    // R1: an untouched buffer programs as all FF
    run_op(3'd3, 127, "R1");
    for (int k = 0; k < RB; k++) read_chk("R1 reset buffer", 127 * RB + k, 8'hFF);

    // R5 program every row with a distinct pattern
    for (int r = 0; r < ROWS; r++) begin
      for (int o = 0; o < RB; o++) load(o, pat(r, o, 8'h00));
      read_chk("R3 load leaves memory", r * RB, mdl[r * RB]);
      run_op(3'd3, r, "R5");
    end
    sweep("R2/R5 contents after program");

    // R4 erase every third row
    for (int r = 0; r < ROWS; r += 3) run_op(3'd2, r, "R4");
    sweep("R4 contents after erase");

    // R6 erase-then-program on a subset
    for (int r = 1; r < ROWS; r += 5) begin
      for (int o = 0; o < RB; o++) load(o, pat(r, o, 8'hA5));
      run_op(3'd4, r, "R6");
    end
    sweep("R6 contents after erase-program");

    // R8 commands while busy are rejected
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'd2;
    cmd_row   = 7'd10;
    @(negedge clk);
    chk("R8 busy after erase", busy, 1'b1);
    cmd_op     = 3'd1;
    cmd_offset = 4'd0;
    cmd_data   = ~mbuf[0];
    @(negedge clk);
    chk("R8 load rejected", err, 1'b1);
    cmd_op  = 3'd2;
    cmd_row = 7'd20;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 erase rejected", err, 1'b1);
    while (busy) @(negedge clk);
    for (int k = 0; k < RB; k++) mdl[10 * RB + k] = 8'hFF;
    for (int k = 0; k < RB; k++) read_chk("R8 other row intact", 20 * RB + k, mdl[20 * RB + k]);
    run_op(3'd3, 30, "R8");
    for (int k = 0; k < RB; k++) read_chk("R8 buffer intact", 30 * RB + k, mbuf[k]);

    // R9 undefined opcodes
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = (i == 0) ? 3'd0 : 3'(4 + i);
      cmd_row   = 7'd40;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9 bad opcode", {err, busy}, 2'b10);
      for (int k = 0; k < RB; k++) read_chk("R9 row unchanged", 40 * RB + k, mdl[40 * RB + k]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule